// File: doc/BRIEF.md
# Receive FIFO with Per-Character Error Tags

This block is the receive store of a serial port. Each character arrives from the receive shifter with parity-error and framing-error tags. The block holds up to sixteen of these characters in arrival order, and the tags stay attached to their character. A break detector watches the serial line and counts bit-time ticks while the line is low. When the low time exceeds one full character frame, the detector inserts a single zero character tagged as a break.

Status bits for parity, framing and break describe the character at the head of the store only. The first status read while a character sits at the head reports its tags and then clears them. A summary flag tells software that an errored character is present somewhere in the store. A status read clears that flag only when no errored character waits behind the head. A compatibility mode shrinks the store to a single holding slot and forces the summary flag to zero.

Top module: `rx_tagged_fifo`

## Requirements
- R1: Characters leave in the order they were written. `dataReady` is 1 exactly when the store holds at least one entry, and `rdData` shows the head character. A pop (`rdPop`) on an empty store has no effect.
- R2: With `fifoModeEn`=1 the store holds 16 entries. A write while full, with no pop in the same cycle, is dropped and leaves the stored contents unchanged. It raises `overrunPulse` for exactly one cycle, in the cycle after the write.
- R3: With `fifoModeEn`=0 the store holds one entry. A second write before a pop is dropped and raises `overrunPulse`. `fifoErrFlag` stays 0 even when the head carries a tag.
- R4: `headParErr`, `headFrmErr` and `headBrk` reflect the tags of the head entry only. Tags of entries behind the head are not visible on them.
- R5: A `statusRead` while an entry is at the head clears that entry's reported tags. The tags are reported again only for the next entry that reaches the head.
- R6: The line is sampled on each `bitTick`. The frame length is F = 1 + (5 + `cfgDataBits`) + `cfgParityEn` + (1 + `cfgStopTwo`), where `cfgDataBits` codes 0..3 select 5..8 data bits. On the (F+1)-th consecutive low sample, one zero character with only the break tag set is stored. A high sample restarts the count.
- R7: A single break stores only one zero character, however long the line stays low. Writes from the shifter are ignored from the break until a `bitTick` samples the line high.
- R8: In FIFO mode, `fifoErrFlag` is 1 whenever an entry with a parity, framing or break tag is in the store. This includes entries behind the head.
- R9: A `statusRead` clears `fifoErrFlag` only if no tagged entry remains behind the head. Otherwise the flag stays 1.
- R10: After reset the store is empty and `dataReady`, all head tags, `fifoErrFlag` and `overrunPulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoModeEn | input | 1 | 1 = 16-entry FIFO, 0 = single holding slot |
| cfgDataBits | input | 2 | Data bits per frame minus five |
| cfgParityEn | input | 1 | Frame carries a parity bit |
| cfgStopTwo | input | 1 | Frame carries two stop bits |
| bitTick | input | 1 | One-cycle strobe per bit time |
| rxLine | input | 1 | Serial receive line, low = spacing |
| wrValid | input | 1 | Shifter delivers a character |
| wrData | input | 8 | Character from the shifter |
| wrParErr | input | 1 | Parity error tag for the character |
| wrFrmErr | input | 1 | Framing error tag for the character |
| rdPop | input | 1 | CPU reads (removes) the head character |
| statusRead | input | 1 | CPU reads the line status |
| rdData | output | 8 | Head character |
| dataReady | output | 1 | Store is not empty |
| headParErr | output | 1 | Unreported parity tag of the head |
| headFrmErr | output | 1 | Unreported framing tag of the head |
| headBrk | output | 1 | Unreported break tag of the head |
| fifoErrFlag | output | 1 | A tagged entry is pending in the store |
| overrunPulse | output | 1 | A write was dropped because the store was full |

## Verification
The assertions assume that `fifoModeEn` changes only while reset is held, so the occupancy never exceeds the capacity of the current mode. They also assume that `bitTick` is a single-cycle strobe. The directed stimulus applies a reset before every mode or frame-format change. It drives all inputs at the falling edge and gives each tick, write, pop and status read as a one-cycle pulse. Break scenarios run the tick count just short of, exactly at and well beyond the frame length. They also cover a high sample in mid-count.

// File: rtl/rx_tagged_fifo_pkg.sv
package rx_tagged_fifo_pkg;

  localparam int unsigned CHAR_W = 8;

  // one stored character together with its tags
  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              parErr;
    logic              frmErr;
    logic              brk;
  } rxEntry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     push;
    logic     pop;
    rxEntry_t wrEntry;
  } fifoStrobe_t;

  function automatic logic isTagged(input rxEntry_t e);
    return e.parErr | e.frmErr | e.brk;
  endfunction

endpackage

// File: rtl/rx_tagged_fifo_dp.sv
module rx_tagged_fifo_dp
  import rx_tagged_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       stb,
  output rxEntry_t          headEntry,
  output logic [LVL_W-1:0]  level
);

  rxEntry_t         store [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else begin
      if (stb.push) begin
        store[wrPtr] <= stb.wrEntry;
        wrPtr        <= nextPtr(wrPtr);
      end
      if (stb.pop) rdPtr <= nextPtr(rdPtr);
      case ({stb.push, stb.pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign headEntry = store[rdPtr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH)); // R2

  AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop |-> level != '0); // R1

  AST_POP_DECR: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop && !stb.push |=> level == $past(level) - 1'b1); // R1

  AST_BREAK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.push && stb.wrEntry.brk |-> stb.wrEntry.data == '0); // R6

endmodule

// File: rtl/rx_break_detect.sv
module rx_break_detect
  import rx_tagged_fifo_pkg::*;
#(
  localparam int unsigned MAX_FRAME = 1 + CHAR_W + 1 + 2,
  localparam int unsigned CNT_W     = $clog2(MAX_FRAME + 2)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       rxLine,
  input  logic [1:0] cfgDataBits,
  input  logic       cfgParityEn,
  input  logic       cfgStopTwo,
  output logic       brkPulse,
  output logic       brkLock
);

  logic [CNT_W-1:0] lowCnt;
  logic [CNT_W-1:0] frameBits;

  // start + data + parity + stop
  assign frameBits = CNT_W'(1) + CNT_W'(5) + CNT_W'(cfgDataBits)
                   + CNT_W'(cfgParityEn) + CNT_W'(1) + CNT_W'(cfgStopTwo);

  // fires on the sample that makes the low run one longer than a frame
  assign brkPulse = bitTick && !rxLine && !brkLock && (lowCnt == frameBits);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= '0;
      brkLock <= 1'b0;
    end else if (bitTick) begin
      if (rxLine) begin
        lowCnt  <= '0;
        brkLock <= 1'b0;
      end else begin
        if (lowCnt != '1) lowCnt <= lowCnt + 1'b1;
        if (brkPulse) brkLock <= 1'b1;
      end
    end
  end

  AST_SINGLE_BREAK: assert property (@(posedge clk) disable iff (!rstN)
    brkPulse |=> !brkPulse); // R7

  AST_LOCK_AFTER_BREAK: assert property (@(posedge clk) disable iff (!rstN)
    brkPulse |=> brkLock); // R7

endmodule

// File: rtl/rx_tagged_fifo_ctrl.sv
module rx_tagged_fifo_ctrl
  import rx_tagged_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoModeEn,
  input  logic              wrValid,
  input  logic [CHAR_W-1:0] wrData,
  input  logic              wrParErr,
  input  logic              wrFrmErr,
  input  logic              rdPop,
  input  logic              statusRead,
  input  logic              brkPulse,
  input  logic              brkLock,
  input  logic              headParTag,
  input  logic              headFrmTag,
  input  logic              headBrkTag,
  input  logic [LVL_W-1:0]  level,
  output fifoStrobe_t       stb,
  output logic              dataReady,
  output logic              headParErr,
  output logic              headFrmErr,
  output logic              headBrk,
  output logic              fifoErrFlag,
  output logic              overrunPulse
);

  logic             full;
  logic             wantPush;
  logic             popOk;
  logic             accept;
  logic             headTagged;
  logic             headSeen;
  logic [LVL_W-1:0] tagCnt;
  logic [LVL_W-1:0] tagsPending;

  assign dataReady  = (level != '0);
  assign full       = fifoModeEn ? (level == LVL_W'(DEPTH)) : dataReady;
  assign wantPush   = brkPulse || (wrValid && !brkLock);
  assign popOk      = rdPop && dataReady;
  assign accept     = wantPush && (!full || popOk);
  assign headTagged = headParTag || headFrmTag || headBrkTag;

  always_comb begin
    stb.push = accept;
    stb.pop  = popOk;
    if (brkPulse) begin
      stb.wrEntry = '{data: '0, parErr: 1'b0, frmErr: 1'b0, brk: 1'b1};
    end else begin
      stb.wrEntry = '{data: wrData, parErr: wrParErr, frmErr: wrFrmErr, brk: 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagCnt       <= '0;
      headSeen     <= 1'b0;
      overrunPulse <= 1'b0;
    end else begin
      overrunPulse <= wantPush && !accept;
      tagCnt <= tagCnt + LVL_W'(accept && isTagged(stb.wrEntry))
                       - LVL_W'(popOk && headTagged);
      if (popOk)                         headSeen <= 1'b0;
      else if (statusRead && dataReady)  headSeen <= 1'b1;
    end
  end

  // tagged entries not yet covered by a status read
  assign tagsPending = tagCnt - LVL_W'(headTagged && headSeen && dataReady);

  assign headParErr  = dataReady && !headSeen && headParTag;
  assign headFrmErr  = dataReady && !headSeen && headFrmTag;
  assign headBrk     = dataReady && !headSeen && headBrkTag;
  assign fifoErrFlag = fifoModeEn && (tagsPending != '0);

  AST_TAGS_WITHIN_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    tagCnt <= level); // R8

  AST_OVERRUN_WHEN_OCCUPIED: assert property (@(posedge clk) disable iff (!rstN)
    overrunPulse |-> $past(level) != '0); // R2

  AST_OVERRUN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    overrunPulse && !wantPush |=> !overrunPulse); // R2

endmodule

// File: rtl/rx_tagged_fifo.sv
module rx_tagged_fifo
  import rx_tagged_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoModeEn,
  input  logic [1:0]        cfgDataBits,
  input  logic              cfgParityEn,
  input  logic              cfgStopTwo,
  input  logic              bitTick,
  input  logic              rxLine,
  input  logic              wrValid,
  input  logic [CHAR_W-1:0] wrData,
  input  logic              wrParErr,
  input  logic              wrFrmErr,
  input  logic              rdPop,
  input  logic              statusRead,
  output logic [CHAR_W-1:0] rdData,
  output logic              dataReady,
  output logic              headParErr,
  output logic              headFrmErr,
  output logic              headBrk,
  output logic              fifoErrFlag,
  output logic              overrunPulse
);

  fifoStrobe_t      stb;
  rxEntry_t         headEntry;
  logic [LVL_W-1:0] level;
  logic             brkPulse;
  logic             brkLock;

  rx_break_detect uBrk (
    .clk         (clk),
    .rstN        (rstN),
    .bitTick     (bitTick),
    .rxLine      (rxLine),
    .cfgDataBits (cfgDataBits),
    .cfgParityEn (cfgParityEn),
    .cfgStopTwo  (cfgStopTwo),
    .brkPulse    (brkPulse),
    .brkLock     (brkLock)
  );

  rx_tagged_fifo_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .fifoModeEn   (fifoModeEn),
    .wrValid      (wrValid),
    .wrData       (wrData),
    .wrParErr     (wrParErr),
    .wrFrmErr     (wrFrmErr),
    .rdPop        (rdPop),
    .statusRead   (statusRead),
    .brkPulse     (brkPulse),
    .brkLock      (brkLock),
    .headParTag   (headEntry.parErr),
    .headFrmTag   (headEntry.frmErr),
    .headBrkTag   (headEntry.brk),
    .level        (level),
    .stb          (stb),
    .dataReady    (dataReady),
    .headParErr   (headParErr),
    .headFrmErr   (headFrmErr),
    .headBrk      (headBrk),
    .fifoErrFlag  (fifoErrFlag),
    .overrunPulse (overrunPulse)
  );

  rx_tagged_fifo_dp #(.DEPTH(DEPTH)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .headEntry (headEntry),
    .level     (level)
  );

  assign rdData = headEntry.data;

  AST_COMPAT_FLAG_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !fifoModeEn |-> !fifoErrFlag); // R3

  AST_COMPAT_ONE_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    !fifoModeEn |-> level <= LVL_W'(1)); // R3

endmodule

// File: tb/rx_tagged_fifo_test.sv
`timescale 1ns/1ps
module rx_tagged_fifo_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fifoModeEn = 1'b1;
  logic [1:0] cfgDataBits = 2'd3;
  logic       cfgParityEn = 1'b0;
  logic       cfgStopTwo = 1'b0;
  logic       bitTick = 1'b0;
  logic       rxLine = 1'b1;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic       wrParErr = 1'b0;
  logic       wrFrmErr = 1'b0;
  logic       rdPop = 1'b0;
  logic       statusRead = 1'b0;
  logic [7:0] rdData;
  logic       dataReady, headParErr, headFrmErr, headBrk, fifoErrFlag, overrunPulse;

  int  chkCnt = 0;
  int  errCnt = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  rx_tagged_fifo uut (
    .clk(clk), .rstN(rstN), .fifoModeEn(fifoModeEn), .cfgDataBits(cfgDataBits),
    .cfgParityEn(cfgParityEn), .cfgStopTwo(cfgStopTwo), .bitTick(bitTick),
    .rxLine(rxLine), .wrValid(wrValid), .wrData(wrData), .wrParErr(wrParErr),
    .wrFrmErr(wrFrmErr), .rdPop(rdPop), .statusRead(statusRead), .rdData(rdData),
    .dataReady(dataReady), .headParErr(headParErr), .headFrmErr(headFrmErr),
    .headBrk(headBrk), .fifoErrFlag(fifoErrFlag), .overrunPulse(overrunPulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic mode, input logic [1:0] db, input logic par, input logic st2);
    @(negedge clk);
    rstN = 1'b0; fifoModeEn = mode; cfgDataBits = db; cfgParityEn = par; cfgStopTwo = st2;
    rxLine = 1'b1; wrValid = 1'b0; rdPop = 1'b0; statusRead = 1'b0; bitTick = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pushChar(input logic [7:0] d, input logic p, input logic f);
    wrValid = 1'b1; wrData = d; wrParErr = p; wrFrmErr = f;
    @(negedge clk);
    wrValid = 1'b0; wrParErr = 1'b0; wrFrmErr = 1'b0;
  endtask

  task automatic popChar();
    rdPop = 1'b1;
    @(negedge clk);
    rdPop = 1'b0;
  endtask

  task automatic statRd();
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
  endtask

  task automatic ticks(input logic line, input int n);
    for (int i = 0; i < n; i++) begin
      rxLine = line; bitTick = 1'b1;
      @(negedge clk);
      bitTick = 1'b0;
    end
  endtask

  task automatic testReset();
    doReset(1'b1, 2'd3, 1'b0, 1'b0);
    chk("R10 dataReady", dataReady, 0);
    chk("R10 tags", {headParErr, headFrmErr, headBrk}, 0);
    chk("R10 fifoErrFlag", fifoErrFlag, 0);
    chk("R10 overrun", overrunPulse, 0);
  endtask

  task automatic testOrder();
    doReset(1'b1, 2'd3, 1'b0, 1'b0);
    popChar();
    chk("R1 pop on empty", dataReady, 0);
    pushChar(8'hA1, 0, 0); pushChar(8'hB2, 0, 0); pushChar(8'hC3, 0, 0);
    chk("R1 ready", dataReady, 1);
    chk("R1 head 1", rdData, 8'hA1);
    popChar(); chk("R1 head 2", rdData, 8'hB2);
    popChar(); chk("R1 head 3", rdData, 8'hC3);
    popChar(); chk("R1 empty", dataReady, 0);
  endtask

  task automatic testFull();
    doReset(1'b1, 2'd3, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++) pushChar(8'(i * 7 + 1), 0, 0);
    chk("R2 no overrun at 16", overrunPulse, 0);
    pushChar(8'hEE, 0, 0);
    chk("R2 overrun pulse", overrunPulse, 1);
    @(negedge clk);
    chk("R2 overrun one cycle", overrunPulse, 0);
    for (int i = 0; i < 16; i++) begin
      chk("R2 contents kept", rdData, 8'(i * 7 + 1));
      popChar();
    end
    chk("R2 dropped char absent", dataReady, 0);
  endtask

  task automatic testCompat();
    doReset(1'b0, 2'd3, 1'b0, 1'b0);
    pushChar(8'h41, 0, 0);
    pushChar(8'h42, 1, 0);
    chk("R3 overrun on second write", overrunPulse, 1);
    chk("R3 head kept", rdData, 8'h41);
    popChar();
    chk("R3 one slot", dataReady, 0);
    pushChar(8'h43, 1, 0);
    chk("R3 head parity shown", headParErr, 1);
    chk("R3 flag held low", fifoErrFlag, 0);
  endtask

  task automatic testTags();
    doReset(1'b1, 2'd3, 1'b0, 1'b0);
    pushChar(8'h10, 0, 0);
    pushChar(8'h20, 1, 0);
    chk("R4 tag behind head hidden", headParErr, 0);
    chk("R8 flag for entry behind head", fifoErrFlag, 1);
    popChar();
    chk("R4 head parity", headParErr, 1);
    chk("R4 head framing", headFrmErr, 0);
    chk("R4 head break", headBrk, 0);
    statRd();
    chk("R5 cleared after status read", headParErr, 0);
    chk("R9 flag clears with nothing behind", fifoErrFlag, 0);
    popChar();
    chk("R8 flag empty", fifoErrFlag, 0);
  endtask

  task automatic testStatusRule();
    doReset(1'b1, 2'd3, 1'b0, 1'b0);
    pushChar(8'h01, 1, 0);
    pushChar(8'h02, 0, 0);
    pushChar(8'h03, 0, 1);
    chk("R8 flag set", fifoErrFlag, 1);
    statRd();
    chk("R9 flag kept with entry behind", fifoErrFlag, 1);
    chk("R5 head parity cleared", headParErr, 0);
    popChar();
    chk("R4 clean head", {headParErr, headFrmErr, headBrk}, 0);
    popChar();
    chk("R5 rearmed on new head", headFrmErr, 1);
    statRd();
    chk("R9 flag clears", fifoErrFlag, 0);
    chk("R5 framing cleared", headFrmErr, 0);
  endtask

  task automatic testBreak();
    doReset(1'b1, 2'd3, 1'b0, 1'b0);
    ticks(1'b0, 8);
    ticks(1'b1, 1);
    ticks(1'b0, 10);
    chk("R6 no break at frame length", dataReady, 0);
    ticks(1'b0, 1);
    chk("R6 break stored", dataReady, 1);
    chk("R6 break char zero", rdData, 0);
    chk("R6 break tag", {headParErr, headFrmErr, headBrk}, 1);
    chk("R8 flag on break", fifoErrFlag, 1);
    ticks(1'b0, 20);
    popChar();
    chk("R7 only one break entry", dataReady, 0);
    pushChar(8'h55, 0, 0);
    chk("R7 write ignored while locked", dataReady, 0);
    chk("R7 no overrun while locked", overrunPulse, 0);
    ticks(1'b1, 1);
    pushChar(8'h56, 0, 0);
    chk("R7 write after release", rdData, 8'h56);
    chk("R7 ready after release", dataReady, 1);
  endtask

  task automatic testBreakCfg();
    doReset(1'b1, 2'd0, 1'b1, 1'b1);
    ticks(1'b0, 9);
    chk("R6 frame 9 not yet", dataReady, 0);
    ticks(1'b0, 1);
    chk("R6 frame 9 break", headBrk, 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      chkCnt++; errCnt++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    testReset();
    testOrder();
    testFull();
    testCompat();
    testTags();
    testStatusRule();
    testBreak();
    testBreakCfg();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule